// File: doc/BRIEF.md
# Multiplexed General-Purpose Pin Port

This block controls a bank of 32 chip pins. Each pin is owned either by the port, where software sets the output level and output enable directly, or by one of four peripheral functions (A to D). If a peripheral owns the pin, that function's drive value and drive enable go to the pad. A simple word-wide register bus holds the per-pin ownership, function selection, drive and sampling controls. Every writable register can also be updated through set, clear and toggle aliases, so software can change single bits without a read-modify-write.

The pad levels go through a two-stage synchronizer into a read-only pin-value register. To save power, each bit of that register updates only while its pin is port-owned or has its interrupt-enable bit set. Otherwise the bit keeps its last captured level. The function code for a pin is split across two mux registers: one holds the low bit and the other the high bit, at the pin's index.

Top module: `pinmux_port`

## Requirements
- R1: After reset, the port-enable register (offset 0x00) reads all ones. The mux-low (0x10), mux-high (0x20), drive-enable (0x30), drive-level (0x40) and sample-enable (0x50) registers read zero. padOe is all zero.
- R2: Each register occupies 16 bytes of address space: base write +0x0, set +0x4, clear +0x8, toggle +0xC. A write at +0x0 loads the full word. A read at any of the four offsets returns the register value.
- R3: A write at the set offset turns on the register bits whose data bits are one and leaves the other bits unchanged.
- R4: A write at the clear offset turns off the register bits whose data bits are one and leaves the other bits unchanged.
- R5: A write at the toggle offset inverts the register bits whose data bits are one and leaves the other bits unchanged.
- R6: The pin-value register at 0x60 is read-only. Writes at offsets 0x60 to 0x6C do not change it.
- R7: When a pin's port-enable bit is one, padOe[n] equals drive-enable bit n and padOut[n] equals drive-level bit n.
- R8: When a pin's port-enable bit is zero, the function code {mux-high[n], mux-low[n]} selects the source for padOut[n] and padOe[n]. Code 0 selects function A, 1 selects B, 2 selects C and 3 selects D. Function f of pin n is bit f*32+n of periphOut and periphOe.
- R9: Let sampling be enabled for a pin. A padIn level held steady before a rising edge appears in the pin-value register after that edge plus two more.
- R10: When both the port-enable and sample-enable bits of a pin are zero, its pin-value bit holds its previous value whatever the pad does.
- R11: A set sample-enable bit alone, with the port-enable bit zero, keeps that pin's pin-value bit updating.
- R12: Reads at an unaligned address, at register index 7 or above, or with any address bit above bit 6 set, return zero. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Levels seen at the pads |
| padOut | output | 32 | Level driven to each pad |
| padOe | output | 32 | Drive enable for each pad |
| periphOut | input | 128 | Drive levels of functions A..D, 32 bits per function |
| periphOe | input | 128 | Drive enables of functions A..D, 32 bits per function |

## Verification
The hardest situation to reach is a pin-value bit that must stay frozen while its pad moves, since the freeze depends on both enable bits being clear and the synchronizer latency hides it. The stimulus first captures a known pad word with every pin port-owned. It then uses the clear alias to release the upper pins and sets sample-enable on only part of them. It changes every pad, waits past the synchronizer, and compares three pin groups: always sampled, kept alive by sample-enable alone, and frozen. A later write at the pin-value offsets shows that the frozen contents are not touched by the bus either.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int PIN_COUNT  = 32;
  localparam int NUM_FUNC   = 4;
  localparam int NUM_WREG   = 6;   // writable registers
  localparam int REG_GPIOEN = 0;
  localparam int REG_MUXLO  = 1;
  localparam int REG_MUXHI  = 2;
  localparam int REG_OUTEN  = 3;
  localparam int REG_OUTVAL = 4;
  localparam int REG_SMPEN  = 5;
  localparam int REG_PINVAL = 6;   // read-only

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic [NUM_WREG-1:0] wrEn;
    wrOp_e               op;
    logic [2:0]          rdSel;
    logic                rdHit;
  } busStb_t;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output busStb_t           stb
);
  logic [2:0] regIdx;
  logic       aligned;
  logic       upperClear;
  logic       mapped;

  assign regIdx     = busAddr[6:4];
  assign aligned    = (busAddr[1:0] == 2'b00);
  assign upperClear = (busAddr[ADDR_W-1:7] == '0);
  assign mapped     = aligned && upperClear && (regIdx <= 3'(REG_PINVAL));

  always_comb begin
    stb.op    = wrOp_e'(busAddr[3:2]);
    stb.rdSel = regIdx;
    stb.rdHit = mapped;
    for (int r = 0; r < NUM_WREG; r++) begin
      stb.wrEn[r] = busWrite && mapped && (regIdx == 3'(r));
    end
  end
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int PINS = PIN_COUNT
) (
  input  logic            clk,
  input  logic            rstN,
  input  busStb_t         stb,
  input  logic [PINS-1:0] busWdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] busRdata,
  output logic [PINS-1:0] gpioEnQ,
  output logic [PINS-1:0] muxLoQ,
  output logic [PINS-1:0] muxHiQ,
  output logic [PINS-1:0] outEnQ,
  output logic [PINS-1:0] outValQ,
  output logic [PINS-1:0] smpEnQ,
  output logic [PINS-1:0] pinValQ
);
  logic [NUM_WREG-1:0][PINS-1:0] regVal;
  logic [PINS-1:0] syncA;
  logic [PINS-1:0] syncB;
  logic [PINS-1:0] sampleEn;

  function automatic logic [PINS-1:0] applyOp(wrOp_e op, logic [PINS-1:0] cur,
                                              logic [PINS-1:0] d);
    case (op)
      OP_LOAD: applyOp = d;
      OP_SET:  applyOp = cur | d;
      OP_CLR:  applyOp = cur & ~d;
      default: applyOp = cur ^ d;
    endcase
  endfunction

  for (genvar r = 0; r < NUM_WREG; r++) begin : g_reg
    localparam logic [PINS-1:0] RST_VAL = (r == REG_GPIOEN) ? '1 : '0;
    logic [PINS-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            q <= RST_VAL;
      else if (stb.wrEn[r]) q <= applyOp(stb.op, q, busWdata);
    end
    assign regVal[r] = q;
  end

  assign gpioEnQ = regVal[REG_GPIOEN];
  assign muxLoQ  = regVal[REG_MUXLO];
  assign muxHiQ  = regVal[REG_MUXHI];
  assign outEnQ  = regVal[REG_OUTEN];
  assign outValQ = regVal[REG_OUTVAL];
  assign smpEnQ  = regVal[REG_SMPEN];

  assign sampleEn = gpioEnQ | smpEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      pinValQ <= '0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      pinValQ <= (syncB & sampleEn) | (pinValQ & ~sampleEn);
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdHit) begin
      if (stb.rdSel == 3'(REG_PINVAL)) busRdata = pinValQ;
      for (int r = 0; r < NUM_WREG; r++) begin
        if (stb.rdSel == 3'(r)) busRdata = regVal[r];
      end
    end
  end
endmodule

// File: rtl/pinmux_padsel.sv
module pinmux_padsel
  import pinmux_pkg::*;
#(
  parameter int PINS = PIN_COUNT,
  parameter int FUNCS = NUM_FUNC
) (
  input  logic [PINS-1:0]       gpioEnQ,
  input  logic [PINS-1:0]       muxLoQ,
  input  logic [PINS-1:0]       muxHiQ,
  input  logic [PINS-1:0]       outEnQ,
  input  logic [PINS-1:0]       outValQ,
  input  logic [FUNCS*PINS-1:0] periphOut,
  input  logic [FUNCS*PINS-1:0] periphOe,
  output logic [PINS-1:0]       padOut,
  output logic [PINS-1:0]       padOe
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [1:0]       fnSel;
    logic [FUNCS-1:0] fnOut;
    logic [FUNCS-1:0] fnOe;
    for (genvar f = 0; f < FUNCS; f++) begin : g_fn
      assign fnOut[f] = periphOut[f*PINS+n];
      assign fnOe[f]  = periphOe[f*PINS+n];
    end
    assign fnSel    = {muxHiQ[n], muxLoQ[n]};
    assign padOut[n] = gpioEnQ[n] ? outValQ[n] : fnOut[fnSel];
    assign padOe[n]  = gpioEnQ[n] ? outEnQ[n]  : fnOe[fnSel];
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PINS   = PIN_COUNT,
  parameter int FUNCS  = NUM_FUNC,
  localparam int PW    = FUNCS * PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  input  logic [PW-1:0]     periphOut,
  input  logic [PW-1:0]     periphOe
);
  busStb_t         stb;
  logic [PINS-1:0] gpioEnQ, muxLoQ, muxHiQ, outEnQ, outValQ, smpEnQ, pinValQ;

  pinmux_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .stb     (stb)
  );

  pinmux_regs #(.PINS(PINS)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busWdata(busWdata),
    .padIn   (padIn),
    .busRdata(busRdata),
    .gpioEnQ (gpioEnQ),
    .muxLoQ  (muxLoQ),
    .muxHiQ  (muxHiQ),
    .outEnQ  (outEnQ),
    .outValQ (outValQ),
    .smpEnQ  (smpEnQ),
    .pinValQ (pinValQ)
  );

  pinmux_padsel #(.PINS(PINS), .FUNCS(FUNCS)) u_padsel (
    .gpioEnQ  (gpioEnQ),
    .muxLoQ   (muxLoQ),
    .muxHiQ   (muxHiQ),
    .outEnQ   (outEnQ),
    .outValQ  (outValQ),
    .periphOut(periphOut),
    .periphOe (periphOe),
    .padOut   (padOut),
    .padOe    (padOe)
  );
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
  parameter int ADDR_W = 8,
  parameter int PINS   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [PINS-1:0]   busWdata,
  input logic [PINS-1:0]   busRdata,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   gpioEnQ,
  input logic [PINS-1:0]   outEnQ,
  input logic [PINS-1:0]   outValQ,
  input logic [PINS-1:0]   smpEnQ,
  input logic [PINS-1:0]   pinValQ
);
  p_plain_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'('h40)) |=> (outValQ == $past(busWdata)));

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'('h34)) |=> (outEnQ == ($past(outEnQ) | $past(busWdata))));

  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'('h38)) |=> (outEnQ == ($past(outEnQ) & ~$past(busWdata))));

  p_tgl_alias_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'('h3C)) |=> (outEnQ == ($past(outEnQ) ^ $past(busWdata))));

  p_port_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ outEnQ) & gpioEnQ) == '0));

  p_port_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((padOut ^ outValQ) & gpioEnQ) == '0));

  p_gated_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((pinValQ ^ $past(pinValQ)) & ~($past(gpioEnQ) | $past(smpEnQ))) == '0));

  p_unaligned_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (busRdata == '0));
endmodule

bind pinmux_port pinmux_port_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWrite(busWrite),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .padOut  (padOut),
  .padOe   (padOe),
  .gpioEnQ (gpioEnQ),
  .outEnQ  (outEnQ),
  .outValQ (outValQ),
  .smpEnQ  (smpEnQ),
  .pinValQ (pinValQ)
);

// File: tb/pinmux_port_test.sv
module pinmux_port_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   busAddr = '0;
  logic         busWrite = 1'b0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [31:0]  padIn = '0;
  logic [31:0]  padOut, padOe;
  logic [127:0] periphOut = '0;
  logic [127:0] periphOe = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pinmux_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut), .periphOe(periphOe)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {req, write, addr, data, expected}
  localparam int NV = 13;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h30, 32'hA5A5_0000, 32'h0},
    {4'd2,  1'b0, 8'h30, 32'h0,         32'hA5A5_0000}, // R2 base read
    {4'd2,  1'b0, 8'h34, 32'h0,         32'hA5A5_0000}, // R2 alias read
    {4'd3,  1'b1, 8'h34, 32'h0000_00FF, 32'h0},
    {4'd3,  1'b0, 8'h30, 32'h0,         32'hA5A5_00FF}, // R3
    {4'd4,  1'b1, 8'h38, 32'h0500_000F, 32'h0},
    {4'd4,  1'b0, 8'h3C, 32'h0,         32'hA0A5_00F0}, // R4
    {4'd5,  1'b1, 8'h3C, 32'hFFFF_0000, 32'h0},
    {4'd5,  1'b0, 8'h38, 32'h0,         32'h5F5A_00F0}, // R5
    {4'd12, 1'b1, 8'hB0, 32'hFFFF_FFFF, 32'h0},
    {4'd12, 1'b1, 8'h32, 32'hFFFF_FFFF, 32'h0},
    {4'd12, 1'b0, 8'h30, 32'h0,         32'h5F5A_00F0}, // R12 writes ignored
    {4'd12, 1'b0, 8'h70, 32'h0,         32'h0}          // R12 unmapped read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pickFn(input logic [127:0] src, input logic [31:0] lo,
                                         input logic [31:0] hi);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = src[{hi[n], lo[n]} * 32 + n];
    return r;
  endfunction

  logic [31:0] rd;
  logic [31:0] expOe, expOut;

  initial begin
    doReset();
    // R1 reset state
    busRd(8'h00, rd); check("R1 port-enable", rd, 32'hFFFF_FFFF);
    busRd(8'h10, rd); check("R1 mux-low", rd, 32'h0);
    busRd(8'h20, rd); check("R1 mux-high", rd, 32'h0);
    busRd(8'h30, rd); check("R1 drive-enable", rd, 32'h0);
    busRd(8'h40, rd); check("R1 drive-level", rd, 32'h0);
    busRd(8'h50, rd); check("R1 sample-enable", rd, 32'h0);
    check("R1 padOe", padOe, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) busWr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        busRd(VEC[i][71:64], rd);
        checks++;
        if (rd !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d row %0d: actual %08h expected %08h",
                   VEC[i][76:73], i, rd, VEC[i][31:0]);
        end
      end
    end

    // R7 port-owned drive
    doReset();
    busWr(8'h30, 32'h00FF_00FF);
    busWr(8'h40, 32'h0F0F_0F0F);
    #1 check("R7 padOe", padOe, 32'h00FF_00FF);
    check("R7 padOut", padOut, 32'h0F0F_0F0F);

    // R8 peripheral functions: A, B, C, D at bits 0..31, 32..63, 64..95, 96..127
    periphOut = {32'hCCCC_CCCC, 32'h3333_3333, 32'hFFFF_0000, 32'h0000_FFFF};
    periphOe  = {32'h5555_5555, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h00FF_00FF};
    busWr(8'h10, 32'h0F0F_0F0F);
    busWr(8'h20, 32'h00FF_00FF);
    busWr(8'h08, 32'hFFFF_FFFF);  // clear all port-enable bits
    #1 check("R8 padOut mixed codes", padOut, pickFn(periphOut, 32'h0F0F_0F0F, 32'h00FF_00FF));
    check("R8 padOe mixed codes", padOe, pickFn(periphOe, 32'h0F0F_0F0F, 32'h00FF_00FF));
    check("R8 pin4 function C", {31'b0, padOut[4]}, {31'b0, periphOut[64+4]});
    busWr(8'h1C, 32'hFFFF_FFFF);  // toggle mux-low
    #1 check("R8 padOut toggled codes", padOut, pickFn(periphOut, 32'hF0F0_F0F0, 32'h00FF_00FF));
    busWr(8'h04, 32'hFFFF_0000);  // upper pins back to port
    expOe  = (32'hFFFF_0000 & 32'h00FF_00FF) | (32'h0000_FFFF & pickFn(periphOe, 32'hF0F0_F0F0, 32'h00FF_00FF));
    expOut = (32'hFFFF_0000 & 32'h0F0F_0F0F) | (32'h0000_FFFF & pickFn(periphOut, 32'hF0F0_F0F0, 32'h00FF_00FF));
    #1 check("R7 R8 split padOe", padOe, expOe);
    check("R7 R8 split padOut", padOut, expOut);

    // R9..R11 pin value capture
    doReset();
    @(negedge clk) padIn = 32'hDEAD_BEEF;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    busRd(8'h60, rd); check("R9 capture", rd, 32'hDEAD_BEEF);
    busWr(8'h08, 32'hFFFF_0000);  // upper 16 pins released
    busWr(8'h50, 32'h00FF_0000);  // sample-enable on bits 16..23
    @(negedge clk) padIn = 32'h1234_5678;
    waitEdges(4);
    busRd(8'h60, rd);
    check("R9 port pins", rd & 32'h0000_FFFF, 32'h0000_5678);
    check("R11 sample-enable only", rd & 32'h00FF_0000, 32'h0034_0000);
    check("R10 frozen", rd & 32'hFF00_0000, 32'hDE00_0000);
    // R6 writes at pin-value offsets
    busWr(8'h60, 32'h0);
    busWr(8'h6C, 32'hFFFF_FFFF);
    busRd(8'h64, rd); check("R6 read-only", rd, 32'hDE34_5678);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule